// File: doc/BRIEF.md
# Stack-Machine Top-of-Stack Datapath

This block is the arithmetic heart of a two-stack processor. It holds the top and second data-stack items in registers. Those two registers drive a combinational ALU at all times, so every result the ALU can produce is ready before the instruction asks for one. A 5-bit opcode, decoded once per instruction cycle, picks which of nine sources is loaded into the top register. The nine sources are the six ALU results, the address register, the return-stack top and the memory read bus.

The block also decides how the surrounding stacks must move. For each instruction it reports whether the data stack is popped into the second register (nip), whether it is pushed, and whether the return stack is popped. The stack memories, the instruction sequencer and the memory port sit outside the block. They supply the address register, the return-stack top, the memory word and the next data-stack item beneath the second register. An execute-enable input marks the cycle in which the decoded instruction takes effect.

Top module: `stk_core`

## Requirements
- R1: While rst_n is low at a clock edge, the top value, the second value and the nip, push and return-pop flags all become zero.
- R2: Opcode 1 loads the bitwise inverse of the top value, and opcode 2 loads the top value shifted left by one with a zero fill. Both leave the second value unchanged and leave all three flags low.
- R3: Opcode 3 loads the top value shifted right by one place, copying bit DW-1 into the vacated top bit. It leaves the second value unchanged and the flags low.
- R4: Opcode 4 (AND), opcode 5 (XOR) and opcode 6 (add) load that combination of the top and second values into the top register. They also assert nip and load the second register from ds_next.
- R5: The sum loaded by opcode 6 is the top value plus the second value, modulo 2^DW. Any carry out of bit DW-1 is lost.
- R6: Opcode 7 (add step) loads top plus second only when bit 0 of the top value is 1. Otherwise the top value is kept. In both cases the second value is unchanged and nip, push and return-pop stay low.
- R7: Opcode 8 loads a_in into the top register, asserts push, and moves the old top value into the second register.
- R8: Opcode 9 loads r_in into the top register, asserts push and return-pop, and moves the old top value into the second register.
- R9: Opcodes 10, 11, 12 and 13 (the memory reads and the literal) load mem_in into the top register, assert push, and move the old top value into the second register. Return-pop stays low.
- R10: Opcode 0 and every opcode from 14 to 31 leave the top and second values unchanged and drive all three flags low.
- R11: At a clock edge where exec_en is low, the top value, the second value and all three flags keep their previous values, whatever the opcode.
- R12: Push and nip are never high together, and return-pop is high only while push is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_en | input | 1 | The decoded opcode takes effect at this edge |
| opcode | input | 5 | Instruction code |
| a_in | input | DW | Address register value |
| r_in | input | DW | Return-stack top |
| mem_in | input | DW | Memory read data |
| ds_next | input | DW | Data-stack item below the second value |
| t_out | output | DW | Top-of-stack register |
| s_out | output | DW | Second-of-stack register |
| nip_out | output | 1 | Last executed instruction popped the data stack |
| push_out | output | 1 | Last executed instruction pushed the data stack |
| rpop_out | output | 1 | Last executed instruction popped the return stack |

## Verification
The bench builds the block with its default width of 20 bits, so the sign bit is bit 19 and an addition wraps at 2^20. At that width the directed cases can reach an add whose carry ripples through every bit slice (all ones plus one), a right shift of a negative value, and add steps with both an odd and an even top value. Random operands and opcodes, including the whole undefined code range, are mixed with random execute-enable gaps. Each result is compared with a bench model of the requirements.

// File: rtl/stk_pkg.sv
// Package: shared opcode codes, T-source selector and control word for the
// stack datapath. Assumes a 5-bit opcode; codes outside 1..13 act as no-ops.
package stk_pkg;

    localparam int OPW = 5;

    // Opcode values (the decoder and the bench both depend on them)
    localparam logic [OPW-1:0] OP_NOP   = 5'd0;
    localparam logic [OPW-1:0] OP_INV   = 5'd1;
    localparam logic [OPW-1:0] OP_SHL   = 5'd2;
    localparam logic [OPW-1:0] OP_SHR   = 5'd3;
    localparam logic [OPW-1:0] OP_AND   = 5'd4;
    localparam logic [OPW-1:0] OP_XOR   = 5'd5;
    localparam logic [OPW-1:0] OP_ADD   = 5'd6;
    localparam logic [OPW-1:0] OP_ADDST = 5'd7;
    localparam logic [OPW-1:0] OP_RDA   = 5'd8;
    localparam logic [OPW-1:0] OP_RDR   = 5'd9;
    localparam logic [OPW-1:0] OP_FET   = 5'd10;
    localparam logic [OPW-1:0] OP_FETI  = 5'd11;
    localparam logic [OPW-1:0] OP_FETR  = 5'd12;
    localparam logic [OPW-1:0] OP_LIT   = 5'd13;

    // Source picked for the next top value
    typedef enum logic [3:0] {
        SRC_HOLD,
        SRC_INV,
        SRC_SHL,
        SRC_SHR,
        SRC_AND,
        SRC_XOR,
        SRC_SUM,
        SRC_AREG,
        SRC_RTOP,
        SRC_MEM
    } tsrc_e;

    // Decoded control word for one instruction
    typedef struct packed {
        tsrc_e src;
        logic  nip;
        logic  push;
        logic  rpop;
    } ctl_t;

endpackage

// File: rtl/stk_alu.sv
// Module: stk_alu
// Continuously computes all six ALU results from the top (t) and second (s)
// values. The AND and XOR terms are the generate/propagate terms of a
// ripple-carry adder, so a single network gives all three two-operand results.
// Assumes DW >= 2. Purely combinational.
module stk_alu #(
    parameter int DW = 20
) (
    input  logic [DW-1:0] t,
    input  logic [DW-1:0] s,
    output logic [DW-1:0] r_inv,
    output logic [DW-1:0] r_shl,
    output logic [DW-1:0] r_shr,
    output logic [DW-1:0] r_and,
    output logic [DW-1:0] r_xor,
    output logic [DW-1:0] r_sum
);

    logic [DW-1:0] gen;
    logic [DW-1:0] prop;
    logic [DW-1:0] carry;

    // Single-operand results: inverse and the two one-place shifts
    always_comb begin
        r_inv = ~t;
        r_shl = {t[DW-2:0], 1'b0};
        r_shr = {t[DW-1], t[DW-1:1]};
    end

    // Per-bit slice: generate, propagate, sum, ripple carry into next slice
    assign carry[0] = 1'b0;
    for (genvar i = 0; i < DW; i++) begin : g_slice
        assign gen[i]   = t[i] & s[i];
        assign prop[i]  = t[i] ^ s[i];
        assign r_sum[i] = prop[i] ^ carry[i];
        if (i < DW - 1) begin : g_cy
            assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
        end
    end

    // The logical results are taken straight from the adder terms
    assign r_and = gen;
    assign r_xor = prop;

    // Ripple chain compared with a behavioural modular add
    always_comb begin
        AST_SUM_WRAPS: assert (r_sum == DW'(t + s)); // R5
    end

endmodule

// File: rtl/stk_decode.sv
// Module: stk_decode
// Turns an opcode into the top-register source and the three stack-control
// bits. The add-step opcode looks at bit 0 of the current top value.
// Assumes undefined opcodes are no-ops. Purely combinational.
module stk_decode
    import stk_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    input  logic           t_lsb,
    output ctl_t           ctl
);

    // Opcode-to-control lookup
    always_comb begin
        ctl = '{src: SRC_HOLD, nip: 1'b0, push: 1'b0, rpop: 1'b0};
        case (opcode)
            OP_INV:   ctl.src = SRC_INV;
            OP_SHL:   ctl.src = SRC_SHL;
            OP_SHR:   ctl.src = SRC_SHR;
            OP_AND:   begin ctl.src = SRC_AND;  ctl.nip  = 1'b1; end
            OP_XOR:   begin ctl.src = SRC_XOR;  ctl.nip  = 1'b1; end
            OP_ADD:   begin ctl.src = SRC_SUM;  ctl.nip  = 1'b1; end
            OP_ADDST: ctl.src = t_lsb ? SRC_SUM : SRC_HOLD;
            OP_RDA:   begin ctl.src = SRC_AREG; ctl.push = 1'b1; end
            OP_RDR:   begin
                ctl.src  = SRC_RTOP;
                ctl.push = 1'b1;
                ctl.rpop = 1'b1;
            end
            OP_FET, OP_FETI, OP_FETR, OP_LIT: begin
                ctl.src  = SRC_MEM;
                ctl.push = 1'b1;
            end
            default:  ctl.src = SRC_HOLD;
        endcase
    end

    // Decoder never asks for both stack directions
    always_comb begin
        AST_DEC_ONE_DIR: assert (!(ctl.nip && ctl.push)); // R12
    end

endmodule

// File: rtl/stk_tmux.sv
// Module: stk_tmux
// Nine-way input selector for the top register, plus a hold path that
// returns the current top value. Assumes sel is a legal tsrc_e value.
module stk_tmux
    import stk_pkg::*;
#(
    parameter int DW = 20
) (
    input  tsrc_e         sel,
    input  logic [DW-1:0] t_cur,
    input  logic [DW-1:0] r_inv,
    input  logic [DW-1:0] r_shl,
    input  logic [DW-1:0] r_shr,
    input  logic [DW-1:0] r_and,
    input  logic [DW-1:0] r_xor,
    input  logic [DW-1:0] r_sum,
    input  logic [DW-1:0] a_val,
    input  logic [DW-1:0] r_val,
    input  logic [DW-1:0] m_val,
    output logic [DW-1:0] t_nxt
);

    // Source selection
    always_comb begin
        case (sel)
            SRC_INV:  t_nxt = r_inv;
            SRC_SHL:  t_nxt = r_shl;
            SRC_SHR:  t_nxt = r_shr;
            SRC_AND:  t_nxt = r_and;
            SRC_XOR:  t_nxt = r_xor;
            SRC_SUM:  t_nxt = r_sum;
            SRC_AREG: t_nxt = a_val;
            SRC_RTOP: t_nxt = r_val;
            SRC_MEM:  t_nxt = m_val;
            default:  t_nxt = t_cur;
        endcase
    end

endmodule

// File: rtl/stk_core.sv
// Module: stk_core
// Top of the stack datapath. It holds the top and second registers and wires
// them to the ALU, the decoder and the top-register selector. It updates the
// registers and the registered stack-control flags on every edge where
// exec_en is high. Assumes the caller presents ds_next as the item under the
// second register. The flags describe the last executed instruction.
module stk_core
    import stk_pkg::*;
#(
    parameter int DW = 20
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           exec_en,
    input  logic [OPW-1:0] opcode,
    input  logic [DW-1:0]  a_in,
    input  logic [DW-1:0]  r_in,
    input  logic [DW-1:0]  mem_in,
    input  logic [DW-1:0]  ds_next,
    output logic [DW-1:0]  t_out,
    output logic [DW-1:0]  s_out,
    output logic           nip_out,
    output logic           push_out,
    output logic           rpop_out
);

    logic [DW-1:0] t_q, s_q;
    logic          nip_q, push_q, rpop_q;
    logic [DW-1:0] r_inv, r_shl, r_shr, r_and, r_xor, r_sum;
    logic [DW-1:0] t_nxt;
    ctl_t          ctl;

    stk_alu #(.DW(DW)) u_alu (
        .t     (t_q),
        .s     (s_q),
        .r_inv (r_inv),
        .r_shl (r_shl),
        .r_shr (r_shr),
        .r_and (r_and),
        .r_xor (r_xor),
        .r_sum (r_sum)
    );

    stk_decode u_dec (
        .opcode (opcode),
        .t_lsb  (t_q[0]),
        .ctl    (ctl)
    );

    stk_tmux #(.DW(DW)) u_mux (
        .sel   (ctl.src),
        .t_cur (t_q),
        .r_inv (r_inv),
        .r_shl (r_shl),
        .r_shr (r_shr),
        .r_and (r_and),
        .r_xor (r_xor),
        .r_sum (r_sum),
        .a_val (a_in),
        .r_val (r_in),
        .m_val (mem_in),
        .t_nxt (t_nxt)
    );

    // Top and second registers: load on execute, second follows push/nip
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
            s_q <= '0;
        end else if (exec_en) begin
            t_q <= t_nxt;
            if (ctl.push) begin
                s_q <= t_q;
            end else if (ctl.nip) begin
                s_q <= ds_next;
            end
        end
    end

    // Stack-control flags of the last executed instruction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nip_q  <= 1'b0;
            push_q <= 1'b0;
            rpop_q <= 1'b0;
        end else if (exec_en) begin
            nip_q  <= ctl.nip;
            push_q <= ctl.push;
            rpop_q <= ctl.rpop;
        end
    end

    assign t_out    = t_q;
    assign s_out    = s_q;
    assign nip_out  = nip_q;
    assign push_out = push_q;
    assign rpop_out = rpop_q;

    // Assertions guarding the register stage
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(exec_en)) |->
            ($stable(t_q) && $stable(s_q) && $stable({nip_q, push_q, rpop_q}))); // R11

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nip_q && push_q) && (!rpop_q || push_q)); // R12

    AST_PUSH_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exec_en) && push_q) |-> (s_q == $past(t_q))); // R7

    AST_NIP_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exec_en) && nip_q) |-> (s_q == $past(ds_next))); // R4

    AST_STEP_EVEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exec_en) && $past(opcode) == OP_ADDST && !$past(t_q[0]))
            |-> (t_q == $past(t_q) && !nip_q && !push_q)); // R6

    AST_NOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exec_en) && ($past(opcode) == OP_NOP || $past(opcode) > OP_LIT))
            |-> ($stable(t_q) && $stable(s_q) && !nip_q && !push_q && !rpop_q)); // R10

endmodule

// File: tb/stk_core_bench.sv
`timescale 1ns/1ps
module stk_core_bench;

    localparam int DW = 20;
    localparam logic [DW-1:0] ALL1 = {DW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          exec_en = 1'b0;
    logic [4:0]    opcode = '0;
    logic [DW-1:0] a_in = '0, r_in = '0, mem_in = '0, ds_next = '0;
    logic [DW-1:0] t_out, s_out;
    logic          nip_out, push_out, rpop_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Model state
    logic [DW-1:0] mt = '0, ms = '0;
    logic          mnip = 1'b0, mpush = 1'b0, mrpop = 1'b0;

    always #10 clk = ~clk;

    stk_core #(.DW(DW)) u_stk_core (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
        .a_in(a_in), .r_in(r_in), .mem_in(mem_in), .ds_next(ds_next),
        .t_out(t_out), .s_out(s_out), .nip_out(nip_out),
        .push_out(push_out), .rpop_out(rpop_out)
    );

    function automatic string req_of(input logic [4:0] op, input logic en);
        if (!en) return "R11";
        case (op)
            5'd1, 5'd2: return "R2";
            5'd3: return "R3";
            5'd4, 5'd5: return "R4";
            5'd6: return "R5";
            5'd7: return "R6";
            5'd8: return "R7";
            5'd9: return "R8";
            5'd10, 5'd11, 5'd12, 5'd13: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [DW-1:0] next_t(input logic [4:0] op,
            input logic [DW-1:0] t, input logic [DW-1:0] s,
            input logic [DW-1:0] a, input logic [DW-1:0] r, input logic [DW-1:0] m);
        case (op)
            5'd1: return ~t;
            5'd2: return t << 1;
            5'd3: return DW'($signed(t) >>> 1);
            5'd4: return t & s;
            5'd5: return t ^ s;
            5'd6: return DW'(t + s);
            5'd7: return t[0] ? DW'(t + s) : t;
            5'd8: return a;
            5'd9: return r;
            5'd10, 5'd11, 5'd12, 5'd13: return m;
            default: return t;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One instruction: drive at negedge, model the edge, compare at next negedge
    task automatic step(input logic en, input logic [4:0] op,
                        input logic [DW-1:0] a, input logic [DW-1:0] r,
                        input logic [DW-1:0] m, input logic [DW-1:0] d);
        logic          pu, ni, rp;
        logic [DW-1:0] nt;
        string         rq;
        exec_en = en; opcode = op; a_in = a; r_in = r; mem_in = m; ds_next = d;
        rq = req_of(op, en);
        if (en) begin
            pu = (op >= 5'd8 && op <= 5'd13);
            ni = (op >= 5'd4 && op <= 5'd6);
            rp = (op == 5'd9);
            nt = next_t(op, mt, ms, a, r, m);
            if (pu) ms = mt; else if (ni) ms = d;
            mt = nt; mnip = ni; mpush = pu; mrpop = rp;
        end
        @(posedge clk);
        @(negedge clk);
        check(rq, "t", t_out, mt);
        check(rq, "s", s_out, ms);
        check(rq, "flags", DW'({nip_out, push_out, rpop_out}), DW'({mnip, mpush, mrpop}));
        check("R12", "excl", DW'((nip_out && push_out) || (rpop_out && !push_out)), '0);
    endtask

    // Load a chosen top and second value through the memory path
    task automatic load_ts(input logic [DW-1:0] t, input logic [DW-1:0] s);
        step(1'b1, 5'd13, '0, '0, s, '0);
        step(1'b1, 5'd13, '0, '0, t, '0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        exec_en = 1'b1; opcode = 5'd8; a_in = 20'h12345;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check("R1", "t", t_out, '0);
        check("R1", "s", s_out, '0);
        check("R1", "flags", DW'({nip_out, push_out, rpop_out}), '0);
        rst_n = 1'b1;
        exec_en = 1'b0;

        // R5: full-length carry wraps to zero
        load_ts(ALL1, 20'h00001);
        step(1'b1, 5'd6, '0, '0, '0, 20'h0abcd);
        // R3: arithmetic right shift of a negative and a positive value
        load_ts(20'h80002, '0);
        step(1'b1, 5'd3, '0, '0, '0, '0);
        load_ts(20'h40002, '0);
        step(1'b1, 5'd3, '0, '0, '0, '0);
        // R6: add step with odd then even top
        load_ts(20'h00003, 20'h00010);
        step(1'b1, 5'd7, '0, '0, '0, 20'h11111);
        load_ts(20'h00004, 20'h00010);
        step(1'b1, 5'd7, '0, '0, '0, 20'h11111);
        // R8: return read pushes and pops return
        step(1'b1, 5'd9, '0, 20'h5a5a5, '0, '0);
        // R11: disabled edge with an active opcode
        step(1'b0, 5'd1, '0, '0, '0, '0);
        // R10: undefined code
        step(1'b1, 5'd31, '0, '0, '0, '0);

        // Random mix
        for (int i = 0; i < 1500; i++) begin
            step(($urandom_range(0, 3) != 0), 5'($urandom_range(0, 31)),
                 DW'($urandom), DW'($urandom), DW'($urandom), DW'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule